// File: doc/BRIEF.md
# Parity Tree Built-In Self-Test

This block tests an embedded two-level parity tree while the tree is otherwise unused. The tree has four 3-input XOR gates. Three leaf gates take nine primary inputs, and one root gate combines the three leaf outputs. The stimulus comes from a seven-stage circular register that holds one word of the length-7 maximal-length cyclic code generated from the primitive polynomial X^3+X+1.

Read over time, each stage of the register carries a different nonzero code word. Every tree input is wired to the stage whose word gives its gate a complete functional test. The expected tree output is also a code word, so it is read straight from a register stage. After the seven rotated patterns, one all-zero pattern finishes the eight-pattern test.

A pulse on `start` loads the register. Each cycle in which `idle` is high applies one pattern, compares the result and advances the test. A mismatch sets a sticky error flag. A fault-injection input can invert any one gate's output so that coverage of single-gate failures can be shown.

Top module: `ptst_top`

## Requirements
- R1: After reset is asserted, `busy`, `done` and `error` are low, and with `fault_en` low `tree_out` is 0.
- R2: A `start` pulse at a clock edge loads the register, clears `done` and `error`, sets `busy`, and restarts the pattern count. This holds even when a test is already running.
- R3: Stage p holds code word W_p, and the register rotates by one position per applied pattern. Over patterns 0..6 the fault-free root output (`tree_out`) is therefore 1,0,1,1,1,0,0, which is the bits of W0 = 1011100 read from left to right.
- R4: A gate that must output W_i takes inputs W_(i+1), W_(i+2) and W_(i+4), with indices mod 7. The root outputs W0, and the leaves output W1, W2 and W4.
- R5: Pattern 7 drives all nine tree inputs to 0, and the fault-free `tree_out` is then 0.
- R6: In every applied pattern, `tree_out` is compared with the stage carrying W0 (forced to 0 in pattern 7). Any mismatch sets `error`, which stays high until the next `start`.
- R7: `done` rises, and `busy` falls, at the edge that applies the eighth pattern. `done` and `busy` are never high together.
- R8: While `idle` is low, the register, the pattern count and `error` hold. A fault present only during such cycles is not flagged.
- R9: When `fault_en` is high, the gate chosen by `fault_sel` has its output inverted. The encoding is 0 = root, 1 = leaf driving W1, 2 = leaf driving W2, 3 = leaf driving W4. Each of the four faults sets `error` over a full test.
- R10: A fault present during only one applied pattern, whether the first, a middle one or the all-zero one, still sets `error` by the end of the test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load the register and begin a test |
| idle | input | 1 | Tree not in use; enables one test step per cycle |
| fault_en | input | 1 | Enable output inversion of one gate |
| fault_sel | input | 2 | Gate to invert: 0 root, 1/2/3 leaves driving W1/W2/W4 |
| busy | output | 1 | Test in progress |
| done | output | 1 | Eight patterns applied |
| error | output | 1 | Sticky mismatch flag |
| tree_out | output | 1 | Parity tree root output |

## Verification
The final comparison and test completion happen at the same clock edge. The zero-pattern mismatch must show up in `error` at the same edge that raises `done` and drops `busy`. The bench provokes this by injecting a fault only during the all-zero pattern, and it judges the result by checking `done`, `busy` and `error` together at the next sample point. It also holds `idle` low between steps with a fault applied, to confirm that a frozen test neither advances nor compares.

// File: rtl/ptst_pkg.sv
package ptst_pkg;
  localparam int K        = 3;
  localparam int STAGES   = (1 << K) - 1;
  localparam int PATTERNS = 1 << K;
  localparam int STEP_W   = $clog2(PATTERNS);
  localparam int FAN_IN   = 3;
  localparam int LEAVES   = 3;
  localparam int PI_CNT   = FAN_IN * LEAVES;
  localparam int FSEL_W   = 2;
  // Bit t is the value of W0 in pattern t (W0 = 1011100 read left to right).
  localparam logic [STAGES-1:0] SEED_SEQ = 7'b0011101;
  // Index offsets: a gate driving W_i takes W_(i+1), W_(i+2), W_(i+4).
  localparam int TAP_OFS [FAN_IN] = '{1, 2, 4};
endpackage

// File: rtl/ptst_ring.sv
module ptst_ring #(
  parameter int STAGES = 7,
  parameter logic [STAGES-1:0] SEED = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  output logic [STAGES-1:0] stage
);
  logic [STAGES-1:0] ring_q, ring_d, init_w;

  // Stage p starts at W0[(-p) mod STAGES] so that it carries W_p over time.
  for (genvar p = 0; p < STAGES; p++) begin : g_init
    localparam int IDX = (STAGES - p) % STAGES;
    assign init_w[p] = SEED[IDX];
  end

  always_comb begin
    ring_d = ring_q;
    if (load)      ring_d = init_w;
    else if (step) ring_d = {ring_q[STAGES-2:0], ring_q[STAGES-1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ring_q <= '0;
    else        ring_q <= ring_d;
  end

  assign stage = ring_q;
endmodule

// File: rtl/ptst_tree.sv
module ptst_tree
  import ptst_pkg::*;
(
  input  logic              [PI_CNT-1:0] pi,
  input  logic                           fault_en,
  input  logic              [FSEL_W-1:0] fault_sel,
  output logic                           root
);
  logic [LEAVES-1:0] leaf;

  for (genvar g = 0; g < LEAVES; g++) begin : g_leaf
    logic flip;
    assign flip    = fault_en && (fault_sel == FSEL_W'(g + 1));
    assign leaf[g] = (^pi[FAN_IN*g +: FAN_IN]) ^ flip;
  end

  assign root = (^leaf) ^ (fault_en && (fault_sel == '0));
endmodule

// File: rtl/ptst_ctrl.sv
module ptst_ctrl
  import ptst_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic idle,
  input  logic mismatch,
  output logic busy,
  output logic done,
  output logic error,
  output logic load,
  output logic step,
  output logic pat_live
);
  logic [STEP_W-1:0] cnt_q, cnt_d;
  logic busy_q, busy_d, done_q, done_d, err_q, err_d;
  logic eval, last;

  assign eval     = busy_q && idle;
  assign last     = (cnt_q == STEP_W'(PATTERNS - 1));
  assign pat_live = busy_q && (cnt_q != STEP_W'(STAGES));
  assign load     = start;
  assign step     = eval && !start;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done_d = done_q;
    err_d  = err_q;
    if (start) begin
      cnt_d  = '0;
      busy_d = 1'b1;
      done_d = 1'b0;
      err_d  = 1'b0;
    end else if (eval) begin
      cnt_d = cnt_q + 1'b1;
      err_d = err_q | mismatch;
      if (last) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign busy  = busy_q;
  assign done  = done_q;
  assign error = err_q;
endmodule

// File: rtl/ptst_top.sv
module ptst_top
  import ptst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              idle,
  input  logic              fault_en,
  input  logic [FSEL_W-1:0] fault_sel,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic              tree_out
);
  logic [STAGES-1:0] stage;
  logic [PI_CNT-1:0] pi;
  logic load, step, pat_live, expect_bit, mismatch;

  ptst_ring #(.STAGES(STAGES), .SEED(SEED_SEQ)) u_ring (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step), .stage(stage)
  );

  // Leaf g drives W_(TAP_OFS[g]); its input m comes from stage TAP_OFS[g]+TAP_OFS[m].
  for (genvar g = 0; g < LEAVES; g++) begin : g_wire
    for (genvar m = 0; m < FAN_IN; m++) begin : g_in
      localparam int SRC = (TAP_OFS[g] + TAP_OFS[m]) % STAGES;
      assign pi[FAN_IN*g + m] = stage[SRC] & pat_live;
    end
  end

  ptst_tree u_tree (
    .pi(pi), .fault_en(fault_en), .fault_sel(fault_sel), .root(tree_out)
  );

  assign expect_bit = stage[0] & pat_live;
  assign mismatch   = tree_out ^ expect_bit;

  ptst_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .idle(idle),
    .mismatch(mismatch), .busy(busy), .done(done), .error(error),
    .load(load), .step(step), .pat_live(pat_live)
  );
endmodule

// File: rtl/ptst_chk.sv
module ptst_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic idle,
  input logic busy,
  input logic done,
  input logic error
);
  // R7
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  // R7
  fall_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R2
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy && !done && !error);
  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error && !start |=> error);
  // R6
  err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> $past(busy) && $past(idle));
  // R8
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !idle && !start |=> busy && $stable(error));
endmodule

bind ptst_top ptst_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .idle(idle),
  .busy(busy), .done(done), .error(error)
);

// File: tb/tb_ptst_top.sv
`timescale 1ns/1ps
module tb_ptst_top;
  logic clk = 1'b0;
  logic rst_n, start, idle, fault_en;
  logic [1:0] fault_sel;
  logic busy, done, error, tree_out;
  int checks = 0;
  int fails  = 0;

  // Fault-free root output per pattern: W0 = 1011100, then the zero pattern.
  localparam logic [7:0] ROOT_SEQ = 8'b00011101;

  typedef struct packed {
    logic       en;
    logic [1:0] sel;
    logic       only;
    logic [2:0] at;
    logic       gap;
    logic       exp_err;
  } case_t;

  localparam int NCASE = 9;
  localparam case_t CASES [NCASE] = '{
    '{1'b0, 2'd0, 1'b0, 3'd0, 1'b0, 1'b0},
    '{1'b0, 2'd0, 1'b0, 3'd0, 1'b1, 1'b0},
    '{1'b1, 2'd0, 1'b0, 3'd0, 1'b0, 1'b1},
    '{1'b1, 2'd1, 1'b0, 3'd0, 1'b0, 1'b1},
    '{1'b1, 2'd2, 1'b0, 3'd0, 1'b0, 1'b1},
    '{1'b1, 2'd3, 1'b0, 3'd0, 1'b0, 1'b1},
    '{1'b1, 2'd2, 1'b1, 3'd7, 1'b0, 1'b1},
    '{1'b1, 2'd3, 1'b1, 3'd3, 1'b1, 1'b1},
    '{1'b1, 2'd1, 1'b1, 3'd0, 1'b0, 1'b1}
  };

  ptst_top dut (
    .clk(clk), .rst_n(rst_n), .start(start), .idle(idle),
    .fault_en(fault_en), .fault_sel(fault_sel), .busy(busy),
    .done(done), .error(error), .tree_out(tree_out)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic run_case(input case_t c);
    @(negedge clk);
    start = 1'b1; idle = 1'b1; fault_en = 1'b0;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !done && !error, "R2 start state", {busy, done, error}, 3'b100);
    for (int t = 0; t < 8; t++) begin
      idle = 1'b1;
      fault_en = c.en && (!c.only || t == int'(c.at));
      fault_sel = c.sel;
      #1;
      chk(tree_out == (ROOT_SEQ[t] ^ fault_en), (t == 7) ? "R5 zero pattern" : "R3 R4 root seq",
          tree_out, ROOT_SEQ[t] ^ fault_en);
      @(negedge clk);
      if (c.gap && t < 7) begin
        idle = 1'b0; fault_en = 1'b1; fault_sel = 2'd0;
        repeat (2) begin
          #1;
          chk(tree_out == !ROOT_SEQ[t+1] && busy, "R8 frozen", {busy, tree_out},
              {1'b1, !ROOT_SEQ[t+1]});
          @(negedge clk);
        end
      end
    end
    fault_en = 1'b0;
    #1;
    chk(done && !busy, "R7 completion", {done, busy}, 2'b10);
    chk(error == c.exp_err, "R6 R9 R10 error", error, c.exp_err);
  endtask

  initial begin
    #(200000 * 5);
    chk(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; idle = 1'b0; fault_en = 1'b0; fault_sel = 2'd0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !error && !tree_out, "R1 reset",
        {busy, done, error, tree_out}, 0);
    rst_n = 1'b1;
    for (int i = 0; i < NCASE; i++) run_case(CASES[i]);

    // R2: restart during a faulty run; the fresh clean test must pass.
    @(negedge clk);
    start = 1'b1; idle = 1'b1;
    @(negedge clk);
    start = 1'b0; fault_en = 1'b1; fault_sel = 2'd1;
    repeat (3) @(negedge clk);
    fault_en = 1'b0;
    #1;
    chk(error && busy, "R6 error mid-run", {error, busy}, 2'b11);
    run_case(CASES[0]);

    // R1: reset in the middle of a run.
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0; fault_en = 1'b1; fault_sel = 2'd3;
    repeat (2) @(negedge clk);
    rst_n = 1'b0; fault_en = 1'b0;
    #1;
    chk(!busy && !done && !error && !tree_out, "R1 reset mid-run",
        {busy, done, error, tree_out}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule